// File: doc/BRIEF.md
# Shared Zero and One Counter

This block is a combinational counting unit for a 32-bit operand. It returns one of three counts: the zeros at the most significant end, the zeros at the least significant end, or the total number of set bits. A two-bit select picks the count. All three share a single chain of 1-bit counting stages. The chain walks from bit 0 upward.

For the leading-zero count, the operand is mirrored before it enters the chain, so the leading zeros arrive at the low end. For the two zero counts, each stage is enabled only while every lower stage has seen a zero, so counting halts at the first one. For the set-bit count, every stage stays enabled and counts ones.

The count is six bits wide and is placed, zero-extended, on a 32-bit result. The block has no clock and holds no state. It is meant to sit inside an execute stage next to the other operand paths.

Top module: `bitcnt_unit`

## Requirements
- R1: With select 2'b10, the result equals the number of one bits in the operand.
- R2: With select 2'b01, the result equals the number of consecutive zero bits starting at bit 0 and ending below the lowest one bit.
- R3: With select 2'b00, the result equals the number of consecutive zero bits starting at bit 31 and ending above the highest one bit.
- R4: An all-zero operand yields 32 for selects 2'b00 and 2'b01, and 0 for select 2'b10.
- R5: An all-ones operand yields 0 for selects 2'b00 and 2'b01, and 32 for select 2'b10.
- R6: Select 2'b11 is reserved and yields a result of 0 for every operand.
- R7: Result bits 31 down to 6 are always zero.
- R8: The result follows any change of operand or select without a clock edge. There is no state, and each result depends only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be counted |
| op_sel_i | input | 2 | 00 leading zeros, 01 trailing zeros, 10 set bits, 11 reserved |
| count_o | output | 32 | Count, zero-extended from six bits |

## Verification
The immediate assertions inside the modules assume that both inputs carry known, settled values whenever the combinational logic is evaluated. They also assume that the select holds one of its four codes.

The bench changes both inputs together, once per clock, right after a rising edge. It compares the result half a period later, so each check sees a settled value. Stimulus covers every single-bit position, the all-zero and all-ones words, and pseudo-random words of varied density under every select code, the reserved code included.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

  typedef enum logic [1:0] {
    CNT_LEAD  = 2'b00,
    CNT_TRAIL = 2'b01,
    CNT_ONES  = 2'b10,
    CNT_RSVD  = 2'b11
  } cnt_op_e;

endpackage

// File: rtl/bitcnt_front.sv
module bitcnt_front
  import bitcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] operand_i,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] chain_vec_o,
  output logic             ones_mode_o
);

  logic [WIDTH-1:0] mirrored;

  for (genvar g = 0; g < WIDTH; g++) begin : g_mirror
    assign mirrored[g] = operand_i[WIDTH-1-g];
  end

  always_comb begin
    chain_vec_o = (op_i == CNT_LEAD) ? mirrored : operand_i;
    ones_mode_o = (op_i == CNT_ONES);
  end

  // R3: the mirrored vector keeps the operand's highest bit at position 0
  always_comb begin
    if (op_i == CNT_LEAD) begin
      p_mirror_ends_r3: assert (chain_vec_o[0] == operand_i[WIDTH-1]);
    end
  end

endmodule

// File: rtl/bitcnt_chain.sv
module bitcnt_chain #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CNT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] vec_i,
  input  logic             ones_mode_i,
  output logic [CNT_W-1:0] count_o
);

  logic [WIDTH-1:0] stage_en;
  logic [WIDTH-1:0] stage_hit;
  logic [CNT_W-1:0] partial [WIDTH+1];

  assign partial[0] = '0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_en[g] = 1'b1;
    end else begin : g_next
      assign stage_en[g] = ones_mode_i | (stage_en[g-1] & ~vec_i[g-1]);
    end
    assign stage_hit[g]  = stage_en[g] & (ones_mode_i ? vec_i[g] : ~vec_i[g]);
    assign partial[g+1]  = partial[g] + CNT_W'(stage_hit[g]);
  end

  assign count_o = partial[WIDTH];

  // R2: in zero-run mode the enables form one unbroken run starting at bit 0
  always_comb begin
    if (!ones_mode_i) begin
      p_enable_run_r2: assert ((stage_en & (stage_en + 1'b1)) == '0);
    end
  end

  // R2: a zero run shorter than the width ends on a one bit
  always_comb begin
    if (!ones_mode_i && count_o < CNT_W'(WIDTH)) begin
      p_run_stops_on_one_r2: assert (vec_i[count_o[CNT_W-2:0]] == 1'b1);
    end
  end

  // R1: the count never exceeds the operand width
  always_comb begin
    p_count_bound_r1: assert (count_o <= CNT_W'(WIDTH));
  end

endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit
  import bitcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CNT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [1:0]       op_sel_i,
  output logic [WIDTH-1:0] count_o
);

  cnt_op_e          op;
  logic [WIDTH-1:0] chain_vec;
  logic             ones_mode;
  logic [CNT_W-1:0] raw_count;

  assign op = cnt_op_e'(op_sel_i);

  bitcnt_front #(.WIDTH(WIDTH)) u_front (
    .operand_i   (operand_i),
    .op_i        (op),
    .chain_vec_o (chain_vec),
    .ones_mode_o (ones_mode)
  );

  bitcnt_chain #(.WIDTH(WIDTH)) u_chain (
    .vec_i       (chain_vec),
    .ones_mode_i (ones_mode),
    .count_o     (raw_count)
  );

  always_comb begin
    count_o = '0;
    if (op != CNT_RSVD) begin
      count_o[CNT_W-1:0] = raw_count;
    end
  end

  // R1: set-bit mode agrees with an independent population count
  always_comb begin
    if (op == CNT_ONES) begin
      p_ones_match_r1: assert (count_o == WIDTH'($countones(operand_i)));
    end
  end

  // R6: reserved select gives zero
  always_comb begin
    if (op == CNT_RSVD) begin
      p_reserved_zero_r6: assert (count_o == '0);
    end
  end

  // R7: upper result bits stay clear
  always_comb begin
    p_upper_clear_r7: assert (count_o[WIDTH-1:CNT_W] == '0);
  end

  // R4: a zero operand gives the full width for both zero counts
  always_comb begin
    if (operand_i == '0 && (op == CNT_LEAD || op == CNT_TRAIL)) begin
      p_zero_full_r4: assert (count_o == WIDTH);
    end
  end

endmodule

// File: tb/bitcnt_unit_test.sv
module bitcnt_unit_test;

  logic        clk;
  logic [31:0] operand;
  logic [1:0]  op_sel;
  logic [31:0] count;
  int          n_run;
  int          n_fail;
  logic [31:0] lfsr;

  bitcnt_unit uut (
    .operand_i (operand),
    .op_sel_i  (op_sel),
    .count_o   (count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ref_count(input logic [31:0] v, input logic [1:0] s);
    int n = 0;
    if (s == 2'b10) begin
      for (int i = 0; i < 32; i++) if (v[i]) n++;
    end else if (s == 2'b01) begin
      for (int i = 0; i < 32; i++) begin
        if (v[i]) break;
        n++;
      end
    end else if (s == 2'b00) begin
      for (int i = 31; i >= 0; i--) begin
        if (v[i]) break;
        n++;
      end
    end
    return n;
  endfunction

  function automatic string req_of(input logic [1:0] s, input logic [31:0] v);
    if (s == 2'b11) return "R6";
    if (v == 32'h0) return "R4";
    if (v == 32'hFFFF_FFFF) return "R5";
    if (s == 2'b10) return "R1";
    if (s == 2'b01) return "R2";
    return "R3";
  endfunction

  task automatic apply(input logic [31:0] v, input logic [1:0] s);
    logic [31:0] exp;
    @(posedge clk);
    operand = v;
    op_sel  = s;
    @(negedge clk);
    exp = 32'(ref_count(v, s));
    n_run++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b operand=%h actual=%0d expected=%0d",
               req_of(s, v), s, v, count, exp);
    end
    // R7: high bits clear
    n_run++;
    if (count[31:6] !== 26'h0) begin
      n_fail++;
      $display("FAIL R7 operand=%h actual=%h expected upper zero", v, count);
    end
  endtask

  initial begin
    n_run  = 0;
    n_fail = 0;
    operand = 32'h0;
    op_sel  = 2'b10;
    lfsr    = 32'hACE1_2468;
    // R4, R5: full-word corner cases under every select
    for (int s = 0; s < 4; s++) begin
      apply(32'h0, 2'(s));
      apply(32'hFFFF_FFFF, 2'(s));
    end
    // R2, R3, R1: a single one at every position
    for (int b = 0; b < 32; b++)
      for (int s = 0; s < 4; s++) apply(32'h1 << b, 2'(s));
    // R2, R3: a one at each end with noise in between
    apply(32'h8000_0001, 2'b00);
    apply(32'h8000_0001, 2'b01);
    apply(32'h0F00_F000, 2'b00);
    apply(32'h0F00_F000, 2'b01);
    // R8: input change without a reset or hold, same operand, new select
    apply(32'h0001_0000, 2'b00);
    apply(32'h0001_0000, 2'b01);
    apply(32'h0001_0000, 2'b10);
    // R1, R2, R3, R6: pseudo-random words of varied density
    for (int k = 0; k < 600; k++) begin
      logic [31:0] w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (k % 4)
        0: w = lfsr;
        1: w = lfsr & {lfsr[15:0], lfsr[31:16]};
        2: w = lfsr << (k % 32);
        default: w = lfsr >> (k % 29);
      endcase
      apply(w, 2'(k % 4));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule